// File: doc/BRIEF.md
# Flip-Position Locator and Message Corrector

This unit carries out the decision step of one iteration of a bit-flipping decoder. It works on word-organised memories of `NB` elements per word. When `start` is pulsed, it runs three phases in turn. First it reads every syndrome word and sums the set bits into a weight. Next it picks a flip threshold according to the range the weight falls in. It then scans the correlation memory row by row and records each element that is strictly larger than the threshold as a (row, index) position. Last, it reads each message word that has recorded positions, inverts those bits and writes the word back to the same address.

A weight of zero means the syndrome is already clear. In that case the unit raises `zero_weight` and finishes without touching the correlation or message memories. The position store holds `ERR_DEPTH` entries. Positions found after it is full are dropped and `overflow` is raised. All three memories are external and read synchronously: a read strobe with an address in one cycle returns data on the next cycle. These memory ports have a fixed latency and no back-pressure, so they use plain strobes instead of a valid/ready handshake. `start`, `done` and the two flags are plain control and status pins.

Top module: `elmc_unit`

## Requirements
- R1: While reset is held and right after it, `done`, `zero_weight`, `overflow` and all memory strobes (`syn_rd`, `cor_rd`, `msg_rd`, `msg_wr`) are 0.
- R2: The weight is the total count of ones over syndrome words 0 to `SYN_ROWS-1`. Each word is read exactly once per run.
- R3: The threshold is selected from the weight: weight < `BOUNDS[0]` gives `THRESH[0]`; `BOUNDS[0]` <= weight < `BOUNDS[1]` gives `THRESH[1]`; weight >= `BOUNDS[1]` gives `THRESH[2]`. Field k of each packed parameter sits at bits [k*width +: width]. The defaults are bounds 8 and 20 with thresholds 12, 10 and 7.
- R4: A correlation element is flagged only if its unsigned value is strictly greater than the threshold. An element equal to the threshold is not flagged. Element k of a correlation word is at bits [k*CW +: CW].
- R5: Flagged positions are stored one per cycle: rows in ascending order, and within a row by ascending index. This order decides which positions survive an overflow.
- R6: Each message row that holds stored positions is read once and written back once, to the same address, with exactly the flagged bits inverted. Bit k of a message word is element k. Rows with no stored position are never written.
- R7: If the weight is 0, `zero_weight` is 1 at `done`, and no correlation read and no message write occur during that run.
- R8: When more than `ERR_DEPTH` positions are flagged, the first `ERR_DEPTH` positions in R5 order are applied, the rest are dropped, and `overflow` is 1 at `done`. Otherwise `overflow` is 0.
- R9: `done` is a single-cycle pulse at the end of each run. `start` is ignored while a run is in progress. Both flags keep their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| done | output | 1 | One-cycle end-of-run pulse |
| zero_weight | output | 1 | Syndrome weight of the last run was 0 |
| overflow | output | 1 | More positions were flagged than the store holds |
| syn_rd | output | 1 | Syndrome memory read strobe |
| syn_addr | output | $clog2(SYN_ROWS) | Syndrome word address |
| syn_rdata | input | NB | Syndrome word, one cycle after strobe |
| cor_rd | output | 1 | Correlation memory read strobe |
| cor_addr | output | $clog2(MSG_ROWS) | Correlation row address |
| cor_rdata | input | NB*CW | Correlation row, one cycle after strobe |
| msg_rd | output | 1 | Message memory read strobe |
| msg_wr | output | 1 | Message memory write strobe |
| msg_addr | output | $clog2(MSG_ROWS) | Message word address for read or write |
| msg_rdata | input | NB | Message word, one cycle after strobe |
| msg_wdata | output | NB | Corrected message word |

## Verification
A wrong weight or a wrong range selection shows up only through the threshold it picks. The bench therefore places correlation values on both sides of each threshold, so a shifted boundary changes which message bits are flipped within the same run. An error in the stored position order or in the store count becomes visible when the store overflows: the wrong positions survive and the final message words differ. A corrupted write-back path shows at `msg_wdata` on the first write. A stray write or correlation read in a run with zero weight is caught by counting strobes at the ports before `done`.

// File: rtl/elmc_pkg.sv
package elmc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SYN_RD, S_SYN_ACC, S_THR,
    S_COR_RD, S_COR_LAT, S_COR_EMIT, S_COR_NEXT,
    S_FIX_RD, S_FIX_LAT, S_FIX_ACC, S_FIX_WR, S_DONE
  } elmc_state_t;
endpackage

// File: rtl/elmc_thresh_lut.sv
module elmc_thresh_lut #(
  parameter int unsigned NR = 3,
  parameter int unsigned BW = 8,
  parameter int unsigned CW = 4,
  parameter logic [(NR-1)*BW-1:0] BOUNDS = '0,
  parameter logic [NR*CW-1:0] THRESH = '0
) (
  input  logic [BW-1:0] weight,
  output logic [CW-1:0] thr
);
  localparam int unsigned SW = $clog2(NR);
  logic [SW-1:0] sel;

  // bounds are ascending: the selected range is the count of bounds reached
  always_comb begin
    sel = '0;
    for (int j = 0; j < NR - 1; j++) begin
      if (weight >= BOUNDS[j*BW +: BW]) sel = SW'(j + 1);
    end
    thr = THRESH[sel*CW +: CW];
  end
endmodule

// File: rtl/elmc_row_compare.sv
module elmc_row_compare #(
  parameter int unsigned NB = 8,
  parameter int unsigned CW = 4
) (
  input  logic [NB*CW-1:0] row,
  input  logic [CW-1:0]    thr,
  output logic [NB-1:0]    gt
);
  for (genvar k = 0; k < NB; k++) begin : g_cmp
    assign gt[k] = row[k*CW +: CW] > thr;
  end
endmodule

// File: rtl/elmc_first_bit.sv
module elmc_first_bit #(
  parameter int unsigned NB = 8,
  parameter int unsigned IW = $clog2(NB)
) (
  input  logic [NB-1:0] vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (vec[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/elmc_err_store.sv
module elmc_err_store #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned EW = 5,
  parameter int unsigned PW = $clog2(DEPTH),
  parameter int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            wr_en,
  input  logic [EW-1:0]   wr_data,
  input  logic [PW-1:0]   rd_ptr,
  output logic [EW-1:0]   rd_data,
  output logic [CNTW-1:0] count,
  output logic            overflow
);
  logic [EW-1:0] mem [DEPTH];
  logic full;

  assign full = (count == CNTW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (wr_en) begin
      if (full) overflow <= 1'b1;
      else      count    <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clear && !full) mem[count[PW-1:0]] <= wr_data;
  end

  assign rd_data = (int'(rd_ptr) < DEPTH) ? mem[rd_ptr] : '0;

  // R8: the flag only rises on a store attempt into a full store
  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_en && full));
endmodule

// File: rtl/elmc_unit.sv
module elmc_unit
  import elmc_pkg::*;
#(
  parameter int unsigned NB        = 8,
  parameter int unsigned CW        = 4,
  parameter int unsigned SYN_ROWS  = 4,
  parameter int unsigned MSG_ROWS  = 4,
  parameter int unsigned ERR_DEPTH = 6,
  parameter int unsigned NR        = 3,
  parameter int unsigned BW        = 8,
  parameter logic [(NR-1)*BW-1:0] BOUNDS = {8'd20, 8'd8},
  parameter logic [NR*CW-1:0]     THRESH = {4'd7, 4'd10, 4'd12},
  localparam int unsigned SAW = $clog2(SYN_ROWS),
  localparam int unsigned MAW = $clog2(MSG_ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             done,
  output logic             zero_weight,
  output logic             overflow,
  output logic             syn_rd,
  output logic [SAW-1:0]   syn_addr,
  input  logic [NB-1:0]    syn_rdata,
  output logic             cor_rd,
  output logic [MAW-1:0]   cor_addr,
  input  logic [NB*CW-1:0] cor_rdata,
  output logic             msg_rd,
  output logic             msg_wr,
  output logic [MAW-1:0]   msg_addr,
  input  logic [NB-1:0]    msg_rdata,
  output logic [NB-1:0]    msg_wdata
);
  localparam int unsigned IW   = $clog2(NB);
  localparam int unsigned EW   = MAW + IW;
  localparam int unsigned PW   = $clog2(ERR_DEPTH);
  localparam int unsigned CNTW = $clog2(ERR_DEPTH + 1);
  localparam int unsigned PCW  = $clog2(NB + 1);

  elmc_state_t state;
  logic [SAW-1:0]  syn_row;
  logic [MAW-1:0]  cor_row, cur_row;
  logic [BW-1:0]   weight;
  logic [CW-1:0]   thr_r, lut_thr;
  logic [NB-1:0]   gt, pend, wbuf, mask;
  logic [IW-1:0]   fb_idx;
  logic [CNTW-1:0] ptr, st_cnt;
  logic [EW-1:0]   ent;
  logic [MAW-1:0]  ent_row;
  logic [IW-1:0]   ent_idx;
  logic            zero_r, st_wr, st_clear;

  function automatic logic [PCW-1:0] ones(input logic [NB-1:0] v);
    logic [PCW-1:0] c;
    c = '0;
    for (int k = 0; k < NB; k++) c = c + PCW'(v[k]);
    return c;
  endfunction

  elmc_thresh_lut #(.NR(NR), .BW(BW), .CW(CW), .BOUNDS(BOUNDS), .THRESH(THRESH))
    u_lut (.weight(weight), .thr(lut_thr));

  elmc_row_compare #(.NB(NB), .CW(CW))
    u_cmp (.row(cor_rdata), .thr(thr_r), .gt(gt));

  elmc_first_bit #(.NB(NB), .IW(IW))
    u_first (.vec(pend), .idx(fb_idx));

  assign st_clear = (state == S_IDLE) && start;
  assign st_wr    = (state == S_COR_EMIT);

  elmc_err_store #(.DEPTH(ERR_DEPTH), .EW(EW), .PW(PW), .CNTW(CNTW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(st_clear), .wr_en(st_wr),
    .wr_data({cor_row, fb_idx}), .rd_ptr(ptr[PW-1:0]), .rd_data(ent),
    .count(st_cnt), .overflow(overflow)
  );

  assign ent_row = ent[EW-1:IW];
  assign ent_idx = ent[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      syn_row <= '0;
      cor_row <= '0;
      cur_row <= '0;
      weight  <= '0;
      thr_r   <= '0;
      pend    <= '0;
      wbuf    <= '0;
      mask    <= '0;
      ptr     <= '0;
      zero_r  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          weight  <= '0;
          syn_row <= '0;
          zero_r  <= 1'b0;
          state   <= S_SYN_RD;
        end
        S_SYN_RD: state <= S_SYN_ACC;
        S_SYN_ACC: begin
          weight <= weight + BW'(ones(syn_rdata));
          if (syn_row == SAW'(SYN_ROWS - 1)) state <= S_THR;
          else begin
            syn_row <= syn_row + 1'b1;
            state   <= S_SYN_RD;
          end
        end
        S_THR: begin
          thr_r   <= lut_thr;
          cor_row <= '0;
          if (weight == '0) begin
            zero_r <= 1'b1;
            state  <= S_DONE;
          end else state <= S_COR_RD;
        end
        S_COR_RD: state <= S_COR_LAT;
        S_COR_LAT: begin
          pend  <= gt;
          state <= (gt == '0) ? S_COR_NEXT : S_COR_EMIT;
        end
        S_COR_EMIT: begin
          pend <= pend & (pend - NB'(1));
          if ((pend & (pend - NB'(1))) == '0) state <= S_COR_NEXT;
        end
        S_COR_NEXT: begin
          if (cor_row == MAW'(MSG_ROWS - 1)) begin
            ptr   <= '0;
            state <= (st_cnt == '0) ? S_DONE : S_FIX_RD;
          end else begin
            cor_row <= cor_row + 1'b1;
            state   <= S_COR_RD;
          end
        end
        S_FIX_RD: begin
          cur_row <= ent_row;
          state   <= S_FIX_LAT;
        end
        S_FIX_LAT: begin
          wbuf  <= msg_rdata;
          mask  <= '0;
          state <= S_FIX_ACC;
        end
        S_FIX_ACC: begin
          if (ptr < st_cnt && ent_row == cur_row) begin
            mask <= mask | (NB'(1) << ent_idx);
            ptr  <= ptr + 1'b1;
          end else state <= S_FIX_WR;
        end
        S_FIX_WR: state <= (ptr == st_cnt) ? S_DONE : S_FIX_RD;
        S_DONE:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign syn_rd      = (state == S_SYN_RD);
  assign syn_addr    = syn_row;
  assign cor_rd      = (state == S_COR_RD);
  assign cor_addr    = cor_row;
  assign msg_rd      = (state == S_FIX_RD);
  assign msg_wr      = (state == S_FIX_WR);
  assign msg_addr    = (state == S_FIX_WR) ? cur_row : ent_row;
  assign msg_wdata   = wbuf ^ mask;
  assign done        = (state == S_DONE);
  assign zero_weight = zero_r;

  // address of the most recent message read, kept for the write-back check
  logic [MAW-1:0] last_rd_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_rd_addr <= '0;
    else if (msg_rd) last_rd_addr <= msg_addr;
  end

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: the write goes back to the word that was read
  a_r6_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    msg_wr |-> msg_addr == last_rd_addr);
  // R7: a clear syndrome causes no scan and no write
  a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    zero_weight |-> !cor_rd && !msg_wr);
  // R5: back-to-back stores within a row carry rising indices
  a_r5_idx_rising: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && $past(st_wr) |-> fb_idx > $past(fb_idx));
  // R2: each syndrome read is followed by its accumulate cycle
  a_r2_syn_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    syn_rd |=> !syn_rd);
endmodule

// File: tb/elmc_unit_tb.sv
module elmc_unit_tb;
  localparam int NB = 8, CW = 4, ROWS = 4, DEPTH = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, zero_weight, overflow, syn_rd, cor_rd, msg_rd, msg_wr;
  logic [1:0] syn_addr, cor_addr, msg_addr;
  logic [NB-1:0] syn_rdata, msg_rdata, msg_wdata;
  logic [NB*CW-1:0] cor_rdata;

  always #4 clk = ~clk;  // 125 MHz

  elmc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .zero_weight(zero_weight), .overflow(overflow),
    .syn_rd(syn_rd), .syn_addr(syn_addr), .syn_rdata(syn_rdata),
    .cor_rd(cor_rd), .cor_addr(cor_addr), .cor_rdata(cor_rdata),
    .msg_rd(msg_rd), .msg_wr(msg_wr), .msg_addr(msg_addr),
    .msg_rdata(msg_rdata), .msg_wdata(msg_wdata)
  );

  logic [NB-1:0]    syn_mem [ROWS];
  logic [NB*CW-1:0] cor_mem [ROWS];
  logic [NB-1:0]    msg_mem [ROWS];
  logic ld_en = 1'b0;
  logic [1:0] ld_addr = '0;
  logic [NB-1:0] ld_data = '0;
  int cor_rd_total = 0, msg_wr_total = 0, done_total = 0;

  always @(posedge clk) begin
    if (syn_rd) syn_rdata <= syn_mem[syn_addr];
    if (cor_rd) cor_rdata <= cor_mem[cor_addr];
    if (msg_rd) msg_rdata <= msg_mem[msg_addr];
    if (ld_en) msg_mem[ld_addr] <= ld_data;
    else if (msg_wr) msg_mem[msg_addr] <= msg_wdata;
    if (cor_rd) cor_rd_total <= cor_rd_total + 1;
    if (msg_wr) msg_wr_total <= msg_wr_total + 1;
    if (done) done_total <= done_total + 1;
  end

  int checks = 0, errors = 0;
  logic [NB-1:0] init_msg [ROWS];
  logic [NB-1:0] exp_msg [ROWS];
  logic exp_zero, exp_ovf;
  int exp_wr, exp_cor;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_msg();
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk); ld_en = 1'b1; ld_addr = 2'(r); ld_data = init_msg[r];
    end
    @(negedge clk); ld_en = 1'b0;
  endtask

  // expected results from R2, R3, R4, R5, R6, R7 and R8
  task automatic model();
    int w, n, b;
    bit hit;
    w = 0; n = 0; exp_wr = 0;
    for (int r = 0; r < ROWS; r++) w += $countones(syn_mem[r]);
    b = (w < 8) ? 12 : (w < 20) ? 10 : 7;
    for (int r = 0; r < ROWS; r++) exp_msg[r] = init_msg[r];
    exp_zero = (w == 0);
    exp_cor  = exp_zero ? 0 : ROWS;
    if (!exp_zero) begin
      for (int r = 0; r < ROWS; r++) begin
        hit = 1'b0;
        for (int k = 0; k < NB; k++) begin
          if (int'(cor_mem[r][k*CW +: CW]) > b) begin
            n++;
            if (n <= DEPTH) begin exp_msg[r][k] = ~exp_msg[r][k]; hit = 1'b1; end
          end
        end
        if (hit) exp_wr++;
      end
    end
    exp_ovf = (n > DEPTH);
  endtask

  task automatic run_check(input string tag);
    int c0, w0, i;
    model();
    load_msg();
    c0 = cor_rd_total; w0 = msg_wr_total;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    i = 0;
    while (!done && i < 2000) begin @(negedge clk); i++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL %s watchdog: actual no done expected done", tag);
    end
    for (int r = 0; r < ROWS; r++) chk({tag, " R6 msg word"}, 32'(msg_mem[r]), 32'(exp_msg[r]));
    chk({tag, " R7 zero flag"}, 32'(zero_weight), 32'(exp_zero));
    chk({tag, " R8 overflow flag"}, 32'(overflow), 32'(exp_ovf));
    chk({tag, " R6 write count"}, 32'(msg_wr_total - w0), 32'(exp_wr));
    chk({tag, " R2 cor reads"}, 32'(cor_rd_total - c0), 32'(exp_cor));
  endtask

  // stimulus vectors: {syndrome words, correlation seed, message words}
  localparam logic [95:0] VEC [0:4] = '{
    {32'h0000_0001, 32'h1234_5678, 32'hA5A5_0F0F},
    {32'h0F0F_0000, 32'h9E37_79B9, 32'h0000_0000},
    {32'hFFFF_0F00, 32'hDEAD_BEEF, 32'hFFFF_FFFF},
    {32'h0101_0103, 32'h0BAD_F00D, 32'h3C3C_C3C3},
    {32'hFFFF_FFFF, 32'h7777_1111, 32'h5555_AAAA}
  };

  initial begin
    logic [31:0] x;
    for (int r = 0; r < ROWS; r++) begin
      syn_mem[r] = '0; cor_mem[r] = '0; msg_mem[r] = '0; init_msg[r] = '0;
    end
    #1;
    // R1 reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 zero flag", 32'(zero_weight), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 strobes", 32'({syn_rd, cor_rd, msg_rd, msg_wr}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", 32'(done), 0);
    chk("R1 strobes after reset", 32'({syn_rd, cor_rd, msg_rd, msg_wr}), 0);

    // vector walk: weights 1, 8, 20, 5, 32 cover every range edge of R3
    for (int v = 0; v < 5; v++) begin
      x = VEC[v][63:32];
      for (int r = 0; r < ROWS; r++) begin
        syn_mem[r]  = VEC[v][64 + r*8 +: 8];
        init_msg[r] = VEC[v][r*8 +: 8];
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        cor_mem[r] = x;
      end
      run_check($sformatf("vec%0d R3 R4 R5", v));
    end

    // R4: values equal to the threshold are not flagged
    syn_mem[0] = 8'h01; syn_mem[1] = '0; syn_mem[2] = '0; syn_mem[3] = '0;
    cor_mem[0] = (32'hC << 8) | (32'hD << 20); cor_mem[1] = '0; cor_mem[2] = '0; cor_mem[3] = '0;
    for (int r = 0; r < ROWS; r++) init_msg[r] = '0;
    run_check("strict R4");
    chk("R4 only index 5 flipped", 32'(msg_mem[0]), 32'h20);

    // R5 + R8: nine flags, store keeps the first six in ascending order
    cor_mem[0] = 32'hFFFF_FFFF; cor_mem[2] = 32'hF000_0000;
    run_check("order R5 R8");
    chk("R5 kept indices 0..5 of row 0", 32'(msg_mem[0]), 32'h3F);
    chk("R8 row 2 dropped", 32'(msg_mem[2]), 0);

    // R7: clear syndrome, correlation that would flag everything
    for (int r = 0; r < ROWS; r++) begin syn_mem[r] = '0; cor_mem[r] = '1; init_msg[r] = 8'h96; end
    run_check("zero R7");

    // R9: a second start during a run is ignored, done pulses once, flags hold
    syn_mem[1] = 8'hFF; syn_mem[2] = 8'hFF; syn_mem[3] = 8'hFF;
    begin
      int d0, i;
      model();
      load_msg();
      d0 = done_total;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      i = 0;
      while (!done && i < 2000) begin @(negedge clk); i++; end
      @(negedge clk);
      chk("R9 done single cycle", 32'(done), 0);
      repeat (20) @(negedge clk);
      chk("R9 one done per start", 32'(done_total - d0), 1);
      chk("R9 overflow held", 32'(overflow), 32'(exp_ovf));
      chk("R9 zero flag held", 32'(zero_weight), 0);
      for (int r = 0; r < ROWS; r++) chk("R9 R6 msg after ignored start", 32'(msg_mem[r]), 32'(exp_msg[r]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule